// File: doc/BRIEF.md
# Timer Input Capture Unit

This block timestamps events against a free-running counter that it holds itself. An event is a chosen transition (rising or falling) on one of two digital inputs: an external capture pin or the output of a comparator. A select input picks the source. The selected signal is synchronized by two flops. It can then pass through an optional noise canceler, which adds latency. An edge detector fires on the chosen transition. On that edge the counter value is copied into a capture register, and in the same cycle a capture flag is set. The flag drives the interrupt request directly.

Software reads the capture register over an 8-bit bus. Reading the low byte also latches the captured high byte into a shared holding register, and a later high-byte read returns that held byte. The two byte reads therefore return one consistent 16-bit value, even if a new capture lands between them. Software clears the flag by writing a one, or the interrupt controller clears it with an acknowledge pulse.

Top module: `icap_unit`

## Requirements
- R1: After reset, count_o, the capture register, irq_o and rdata_o are all zero.
- R2: count_o increases by one every clock and wraps from 16'hFFFF to 0.
- R3: With src_sel_i = 0 the capture pin is the event source and cmp_i is ignored; with src_sel_i = 1 cmp_i is the source and cap_pin_i is ignored.
- R4: With edge_rise_i = 1 only a 0-to-1 transition of the source is an event; with edge_rise_i = 0 only a 1-to-0 transition is an event. The opposite transition never captures.
- R5: With filt_en_i = 0, a source transition driven while count_o reads c is captured with the value c+2, and irq_o rises in that same cycle.
- R6: With filt_en_i = 1, the noise canceler accepts a level only after 4 consecutive equal samples. A transition driven while count_o reads c is captured as c+6. A level held for 3 cycles or fewer produces no capture.
- R7: irq_o rises in the same cycle as the capture register is loaded, not earlier.
- R8: A one on flag_clr_i or a pulse on irq_ack_i clears irq_o on the next clock. If a capture happens in the same cycle, the set wins and irq_o stays high.
- R9: A new capture overwrites the capture register even when the previous value was not read. irq_o then stays high.
- R10: With rd_i = 1, addr_i = 0 returns the low capture byte and latches the high capture byte into a holding register. addr_i = 1 returns the holding register, so a capture between the two reads does not change the high byte returned. With rd_i = 0, rdata_o is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cap_pin_i | input | 1 | External capture input (asynchronous) |
| cmp_i | input | 1 | Comparator result (asynchronous) |
| src_sel_i | input | 1 | Event source: 0 pin, 1 comparator |
| edge_rise_i | input | 1 | Edge select: 1 rising, 0 falling |
| filt_en_i | input | 1 | Noise canceler enable |
| rd_i | input | 1 | Bus read strobe |
| addr_i | input | 1 | Byte select: 0 low, 1 high (held) |
| rdata_o | output | 8 | Bus read data |
| flag_clr_i | input | 1 | Write-one-to-clear of the capture flag |
| irq_ack_i | input | 1 | Interrupt acknowledge, clears the flag |
| irq_o | output | 1 | Capture flag / interrupt request |
| count_o | output | 16 | Free-running counter value |

## Verification
Setting the flag on a capture and clearing it by software or by acknowledge can fall in the same cycle. So can a capture and the low-byte read that latches the holding register. The bench counts the known pipeline latency forward from the cycle it drives the source. It raises the clear and acknowledge strobes so that they meet the capture edge exactly, and it expects the flag to stay set and the register to hold the new value. For the byte pair, it forces a capture between the low and high reads, at a count whose high byte differs from the held one. It expects the old high byte back.

// File: rtl/icap_pkg.sv
package icap_pkg;
  parameter int unsigned BUS_W = 8;
  localparam int unsigned CNT_W = 2 * BUS_W;

  typedef logic [CNT_W-1:0] cnt_t;
  typedef logic [BUS_W-1:0] byte_t;

  typedef enum logic { SRC_PIN = 1'b0, SRC_CMP = 1'b1 } src_e;
endpackage

// File: rtl/icap_sync.sv
module icap_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] stage_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stage_q <= '0;
    else         stage_q <= {stage_q[STAGES-2:0], d_i};
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/icap_filter.sv
module icap_filter #(
  parameter int unsigned LEN = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic d_i,
  output logic level_o
);
  localparam int unsigned RW = $clog2(LEN + 1);
  localparam logic [RW-1:0] LAST = RW'(LEN - 1);

  logic          out_q;
  logic [RW-1:0] run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q <= 1'b0;
      run_q <= '0;
    end else if (!en_i) begin
      // track input while bypassed so enabling never makes a false edge
      out_q <= d_i;
      run_q <= '0;
    end else if (d_i != out_q) begin
      if (run_q == LAST) begin
        out_q <= d_i;
        run_q <= '0;
      end else begin
        run_q <= run_q + 1'b1;
      end
    end else begin
      run_q <= '0;
    end
  end

  assign level_o = en_i ? out_q : d_i;

  // R6
  filt_run_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(out_q) && $past(en_i)) |-> ($past(run_q) == LAST));
endmodule

// File: rtl/icap_edge.sv
module icap_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic level_i,
  input  logic rise_i,
  output logic ev_o
);
  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= level_i;
  end

  assign ev_o = rise_i ? (level_i & ~prev_q) : (~level_i & prev_q);

  // R4
  edge_dir_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_o |=> (prev_q == rise_i));
endmodule

// File: rtl/icap_unit.sv
module icap_unit
  import icap_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned FILT_LEN    = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cap_pin_i,
  input  logic             cmp_i,
  input  logic             src_sel_i,
  input  logic             edge_rise_i,
  input  logic             filt_en_i,
  input  logic             rd_i,
  input  logic             addr_i,
  output logic [BUS_W-1:0] rdata_o,
  input  logic             flag_clr_i,
  input  logic             irq_ack_i,
  output logic             irq_o,
  output logic [CNT_W-1:0] count_o
);
  logic  raw, synced, level, cap_ev, flag_q;
  cnt_t  cnt_q, cap_q;
  byte_t hold_q;

  assign raw = (src_e'(src_sel_i) == SRC_CMP) ? cmp_i : cap_pin_i;

  icap_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(raw), .q_o(synced)
  );

  icap_filter #(.LEN(FILT_LEN)) u_filt (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(filt_en_i), .d_i(synced), .level_o(level)
  );

  icap_edge u_edge (
    .clk_i(clk_i), .rst_ni(rst_ni), .level_i(level), .rise_i(edge_rise_i), .ev_o(cap_ev)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cap_q <= '0;
    else if (cap_ev) cap_q <= cnt_q;
  end

  // set has priority over either clear source
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       flag_q <= 1'b0;
    else if (cap_ev)                   flag_q <= 1'b1;
    else if (flag_clr_i || irq_ack_i)  flag_q <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              hold_q <= '0;
    else if (rd_i && !addr_i) hold_q <= cap_q[CNT_W-1:BUS_W];
  end

  always_comb begin
    rdata_o = '0;
    if (rd_i) rdata_o = addr_i ? hold_q : cap_q[BUS_W-1:0];
  end

  assign irq_o   = flag_q;
  assign count_o = cnt_q;

  // R7
  cap_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_ev |=> (flag_q && cap_q == $past(cnt_q)));
  // R9
  cap_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cap_ev |=> $stable(cap_q));
  // R8
  flag_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((flag_clr_i || irq_ack_i) && !cap_ev) |=> !flag_q);
  // R10
  hold_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !addr_i) |=> (hold_q == $past(cap_q[CNT_W-1:BUS_W])));
  // R2
  cnt_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (count_o == $past(count_o) + 1'b1));
endmodule

// File: tb/icap_unit_test.sv
`timescale 1ns/1ps
module icap_unit_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic pin = 0, cmp = 0, src_sel = 0, edge_rise = 1, filt_en = 0;
  logic rd = 0, addr = 0, clr = 0, ack = 0;
  logic [7:0]  rdata;
  logic        irq;
  logic [15:0] count;
  int n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  icap_unit uut (
    .clk_i(clk), .rst_ni(rst_n), .cap_pin_i(pin), .cmp_i(cmp),
    .src_sel_i(src_sel), .edge_rise_i(edge_rise), .filt_en_i(filt_en),
    .rd_i(rd), .addr_i(addr), .rdata_o(rdata), .flag_clr_i(clr),
    .irq_ack_i(ack), .irq_o(irq), .count_o(count)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive_src(input logic s, input logic v);
    if (s) cmp = v; else pin = v;
  endtask

  task automatic read16(input string req, input logic [15:0] exp);
    rd = 1; addr = 0; #1;
    check(req, rdata, exp[7:0]);
    @(negedge clk); addr = 1; #1;
    check(req, rdata, exp[15:8]);
    @(negedge clk); rd = 0; addr = 0;
  endtask

  task automatic run_combo(input logic s, input logic e, input logic f);
    logic idle, act;
    logic [15:0] c, exp;
    int lat;
    idle = ~e; act = e; lat = f ? 6 : 2;
    @(negedge clk); edge_rise = e; filt_en = f; src_sel = s;
    @(negedge clk); pin = idle; cmp = idle;
    repeat (12) @(negedge clk);
    clr = 1; @(negedge clk); clr = 0;
    check("R8 clear", irq, 0);
    drive_src(~s, act); repeat (12) @(negedge clk);
    check("R3 unselected ignored", irq, 0);
    drive_src(~s, idle); repeat (12) @(negedge clk);
    check("R3 unselected ignored", irq, 0);
    c = count; drive_src(s, act);
    repeat (lat) @(negedge clk);
    check("R7 not early", irq, 0);
    @(negedge clk);
    check("R7 flag on capture", irq, 1);
    exp = c + 16'(lat);
    read16(f ? "R6 filtered capture" : "R5 bypass capture", exp);
    if (e) ack = 1; else clr = 1;
    @(negedge clk); ack = 0; clr = 0;
    check("R8 clear", irq, 0);
    drive_src(s, idle); repeat (14) @(negedge clk);
    check("R4 opposite edge ignored", irq, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] c, first;
    repeat (3) @(negedge clk);
    check("R1 count", count, 0);
    check("R1 irq", irq, 0);
    rd = 1; addr = 0; #1; check("R1 capture low", rdata, 0);
    addr = 1; #1; check("R1 hold", rdata, 0);
    rd = 0; #1; check("R1 rdata idle", rdata, 0);
    rst_n = 1;
    @(negedge clk);
    c = count;
    repeat (300) @(negedge clk);
    check("R2 count step", count, 16'(c + 16'd300));

    for (int k = 0; k < 8; k++) run_combo(k[2], k[1], k[0]);

    // R6 glitch rejection then 4-cycle pulse acceptance
    @(negedge clk); src_sel = 0; edge_rise = 1; filt_en = 1; pin = 0; cmp = 0;
    repeat (12) @(negedge clk);
    pin = 1; repeat (3) @(negedge clk); pin = 0;
    repeat (14) @(negedge clk);
    check("R6 short pulse rejected", irq, 0);
    c = count; pin = 1; repeat (4) @(negedge clk); pin = 0;
    repeat (10) @(negedge clk);
    check("R6 4-sample pulse accepted", irq, 1);
    read16("R6 4-sample capture", 16'(c + 16'd6));
    clr = 1; @(negedge clk); clr = 0;

    // R8 and R9: capture meets clear and ack; overwrite without read
    filt_en = 0; repeat (12) @(negedge clk);
    pin = 1; repeat (6) @(negedge clk);
    check("R9 first capture flag", irq, 1);
    pin = 0; repeat (12) @(negedge clk);
    c = count; pin = 1;
    repeat (2) @(negedge clk);
    clr = 1; ack = 1;
    @(negedge clk); clr = 0; ack = 0;
    check("R8 set wins over clear", irq, 1);
    read16("R9 overwrite", 16'(c + 16'd2));
    pin = 0; repeat (12) @(negedge clk);

    // R10 capture between the two byte reads
    first = c + 16'd2;
    rd = 1; addr = 0; #1;
    check("R10 low byte", rdata, first[7:0]);
    @(negedge clk); rd = 0;
    repeat (300) @(negedge clk);
    c = count; pin = 1; repeat (6) @(negedge clk);
    rd = 1; addr = 1; #1;
    check("R10 held high byte", rdata, first[15:8]);
    @(negedge clk); rd = 0;
    read16("R10 fresh pair", 16'(c + 16'd2));
    pin = 0;

    // R2 wrap
    while (count != 16'hFFFF) @(negedge clk);
    @(negedge clk);
    check("R2 wrap", count, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule